// File: doc/BRIEF.md
# Codec Register Access Sequencer

This block decides, frame by frame, what an audio codec link carries toward the codec. A separate frame engine handles the serial framing. At each frame boundary it pulses a strobe. On that strobe it takes the five outgoing fields (tag plus four 20-bit slots) from this block and hands over the five fields it just received. The sequencer first holds the codec in reset for a fixed number of clock cycles. It then sends empty frames until the codec marks its frames as valid. Next it plays a computed list of register writes, one per frame. From then on it sends PCM frames.

A host can ask for a single register read or write through a request/busy/done handshake. The sequencer places that command into exactly one frame and then returns to PCM traffic. For a read, it watches incoming tags for a status response, keeps the returned register address and value, and pulses done. Received PCM slots are forwarded on every strobe with their low four bits cleared.

Top module: `codec_seq_top`

## Requirements
- R1: `codec_rst_n` is low while `rst_n` is low, stays low through the first RST_CYCLES-1 rising clock edges after `rst_n` goes high, rises on edge RST_CYCLES and never falls again.
- R2: At a strobe where `codec_rst_n` is still low, or where `rx_tag[15]` is 0, the next outgoing frame is all zeros: tag and all four slots. The initialization position and any pending host command are kept unchanged.
- R3: The first INIT_LEN ready strobes each send one initialization write, in index order i = 0, 1, 2, and so on. Each such frame has tag 16'hE000, slot1 = {1'b0, addr, 12'h000}, slot2 = {data, 4'h0}, and slots 3 and 4 zero. Entry i uses addr = 2*i+2 and data = {8'hA5 ^ i[7:0], i[7:0]}.
- R4: After initialization, a ready strobe with no pending command sends a PCM frame: tag 16'h9800, slots 1 and 2 zero, and slots 3 and 4 equal to `pcm_out_l` and `pcm_out_r` as sampled at that strobe.
- R5: A `host_req` sampled while `host_busy` is low is accepted. From the next cycle, `host_busy` is high while the command is pending or a read is outstanding. A request made while `host_busy` is high is ignored and never reaches a frame.
- R6: A pending write goes out at the first ready strobe after initialization, in exactly one frame. Its tag is 16'hE000, slot1 bit 19 is 0 with the address in bits 18:12, slot2 carries the data in bits 19:4, and slots 3 and 4 are zero. The following frames are PCM frames.
- R7: A pending read goes out the same way, in one frame with tag 16'hC000. Slot1 bit 19 is 1 with the address in bits 18:12. Slots 2, 3 and 4 are zero.
- R8: A received frame whose tag has bits 14 and 13 both set is a status response: address from slot1[18:12], data from slot2[19:4]. If a read is outstanding, `host_done` pulses high for one cycle on the clock edge after the response strobe. In that same cycle `host_raddr` and `host_rdata` take the response and `host_busy` falls. With no read outstanding, a response never raises `host_done`.
- R9: A write never raises `host_done`. `host_busy` is low in the cycle after the write's frame strobe.
- R10: On every strobe, `pcm_in_l` and `pcm_in_r` take `rx_slot3` and `rx_slot4` with bits 3:0 cleared, and `pcm_in_stb` is high for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary from the frame engine |
| rx_tag | input | 16 | Received tag |
| rx_slot1 | input | 20 | Received status address slot |
| rx_slot2 | input | 20 | Received status data slot |
| rx_slot3 | input | 20 | Received left PCM slot |
| rx_slot4 | input | 20 | Received right PCM slot |
| pcm_out_l | input | 20 | Left PCM sample to send |
| pcm_out_r | input | 20 | Right PCM sample to send |
| host_req | input | 1 | Host command request |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 7 | Codec register address |
| host_wdata | input | 16 | Write data |
| host_busy | output | 1 | Command pending or read outstanding |
| host_done | output | 1 | One-cycle read completion pulse |
| host_raddr | output | 7 | Address returned by the last completed read |
| host_rdata | output | 16 | Data returned by the last completed read |
| codec_rst_n | output | 1 | Active-low codec reset |
| tx_tag | output | 16 | Outgoing tag |
| tx_slot1 | output | 20 | Outgoing command address slot |
| tx_slot2 | output | 20 | Outgoing command data slot |
| tx_slot3 | output | 20 | Outgoing left PCM slot |
| tx_slot4 | output | 20 | Outgoing right PCM slot |
| pcm_in_l | output | 20 | Received left PCM, low nibble cleared |
| pcm_in_r | output | 20 | Received right PCM, low nibble cleared |
| pcm_in_stb | output | 1 | Received PCM update pulse |

## Verification
The bench checks these corner cases:
- **Not-ready frame in mid-initialization.** A design that advanced its list index anyway would skip an entry.
- **Request raised while busy.** A design that did not ignore it would overwrite the pending command, which then shows up in a later frame.
- **Host write pending through a not-ready frame.** A design that lost it, or sent it twice, would show a missing or repeated command frame.
- **Status response with no read outstanding.** It must produce no done pulse, which catches a done that ignores the outstanding flag.
- **PCM low nibble.** Received slots with nonzero low bits expose a forward path that does not clear them.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int REG_AW = 7;
  localparam int REG_DW = 16;

  localparam logic [TAG_W-1:0] TAG_NONE = 16'h0000;
  localparam logic [TAG_W-1:0] TAG_WR   = 16'hE000;
  localparam logic [TAG_W-1:0] TAG_RD   = 16'hC000;
  localparam logic [TAG_W-1:0] TAG_PCM  = 16'h9800;

  typedef struct packed {
    logic              rd;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } reg_cmd_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [SLOT_W-1:0] s1;
    logic [SLOT_W-1:0] s2;
    logic [SLOT_W-1:0] s3;
    logic [SLOT_W-1:0] s4;
  } tx_frame_t;

  function automatic logic [SLOT_W-1:0] addr_slot(logic rd, logic [REG_AW-1:0] a);
    return {rd, a, 12'h000};
  endfunction

  function automatic logic [SLOT_W-1:0] data_slot(logic [REG_DW-1:0] d);
    return {d, 4'h0};
  endfunction

  function automatic logic [REG_AW-1:0] slot_addr(logic [SLOT_W-1:0] s);
    return s[18:12];
  endfunction

  function automatic logic [REG_DW-1:0] slot_data(logic [SLOT_W-1:0] s);
    return s[19:4];
  endfunction

  function automatic logic [SLOT_W-1:0] clr_nibble(logic [SLOT_W-1:0] s);
    return s & 20'hFFFF0;
  endfunction

  function automatic logic tag_ready(logic [TAG_W-1:0] t);
    return t[15];
  endfunction

  function automatic logic tag_status(logic [TAG_W-1:0] t);
    return t[14] & t[13];
  endfunction

  function automatic reg_cmd_t init_cmd(int unsigned idx);
    reg_cmd_t   c;
    logic [7:0] i8;
    i8     = 8'(idx);
    c.rd   = 1'b0;
    c.addr = 7'(2 * idx + 2);
    c.data = {i8 ^ 8'hA5, i8};
    return c;
  endfunction

  function automatic tx_frame_t cmd_frame(reg_cmd_t c);
    tx_frame_t f;
    f.tag = c.rd ? TAG_RD : TAG_WR;
    f.s1  = addr_slot(c.rd, c.addr);
    f.s2  = c.rd ? '0 : data_slot(c.data);
    f.s3  = '0;
    f.s4  = '0;
    return f;
  endfunction

  function automatic tx_frame_t pcm_frame(logic [SLOT_W-1:0] l, logic [SLOT_W-1:0] r);
    tx_frame_t f;
    f.tag = TAG_PCM;
    f.s1  = '0;
    f.s2  = '0;
    f.s3  = l;
    f.s4  = r;
    return f;
  endfunction
endpackage

// File: rtl/codec_rst_timer.sv
module codec_rst_timer #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic released
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (!released) begin
      if (cnt == CNT_W'(RST_CYCLES - 1)) released <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/codec_status_rx.sv
module codec_status_rx
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic [SLOT_W-1:0] rx_slot2,
  input  logic [SLOT_W-1:0] rx_slot3,
  input  logic [SLOT_W-1:0] rx_slot4,
  output logic              codec_ready_now,
  output logic              resp_seen,
  output logic [REG_AW-1:0] resp_addr,
  output logic [REG_DW-1:0] resp_data,
  output logic [SLOT_W-1:0] pcm_in_l,
  output logic [SLOT_W-1:0] pcm_in_r,
  output logic              pcm_in_stb
);
  assign codec_ready_now = tag_ready(rx_tag);
  assign resp_seen       = frame_stb & tag_status(rx_tag);
  assign resp_addr       = slot_addr(rx_slot1);
  assign resp_data       = slot_data(rx_slot2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcm_in_l   <= '0;
      pcm_in_r   <= '0;
      pcm_in_stb <= 1'b0;
    end else begin
      pcm_in_stb <= frame_stb;
      if (frame_stb) begin
        pcm_in_l <= clr_nibble(rx_slot3);
        pcm_in_r <= clr_nibble(rx_slot4);
      end
    end
  end
endmodule

// File: rtl/codec_host_port.sv
module codec_host_port
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_rd,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [REG_DW-1:0] host_wdata,
  input  logic              cmd_taken,
  input  logic              resp_seen,
  input  logic [REG_AW-1:0] resp_addr,
  input  logic [REG_DW-1:0] resp_data,
  output logic              cmd_pending,
  output reg_cmd_t          cmd,
  output logic              host_busy,
  output logic              host_done,
  output logic [REG_AW-1:0] host_raddr,
  output logic [REG_DW-1:0] host_rdata
);
  logic              rd_out;
  logic              resp_valid;
  logic [REG_AW-1:0] cap_addr;
  logic [REG_DW-1:0] cap_data;
  logic              accept;
  logic              done_fire;

  assign host_busy = cmd_pending | rd_out;
  assign accept    = host_req & ~host_busy;
  assign done_fire = rd_out & resp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_pending <= 1'b0;
      cmd         <= '0;
      rd_out      <= 1'b0;
      resp_valid  <= 1'b0;
      cap_addr    <= '0;
      cap_data    <= '0;
      host_done   <= 1'b0;
      host_raddr  <= '0;
      host_rdata  <= '0;
    end else begin
      host_done <= done_fire;
      if (accept) begin
        cmd_pending <= 1'b1;
        cmd         <= '{rd: host_rd, addr: host_addr, data: host_wdata};
        rd_out      <= host_rd;
      end else begin
        if (cmd_taken) cmd_pending <= 1'b0;
        if (done_fire) rd_out <= 1'b0;
      end
      if (accept && host_rd)  resp_valid <= 1'b0;
      else if (resp_seen)     resp_valid <= 1'b1;
      else if (done_fire)     resp_valid <= 1'b0;
      if (resp_seen) begin
        cap_addr <= resp_addr;
        cap_data <= resp_data;
      end
      if (done_fire) begin
        host_raddr <= cap_addr;
        host_rdata <= cap_data;
      end
    end
  end
endmodule

// File: rtl/codec_frame_builder.sv
module codec_frame_builder
  import codec_seq_pkg::*;
#(
  parameter int INIT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              released,
  input  logic              codec_ready_now,
  input  logic              cmd_pending,
  input  reg_cmd_t          cmd,
  input  logic [SLOT_W-1:0] pcm_out_l,
  input  logic [SLOT_W-1:0] pcm_out_r,
  output logic              cmd_taken,
  output logic              init_done,
  output tx_frame_t         tx
);
  localparam int IDX_W = $clog2(INIT_LEN + 1);

  logic [IDX_W-1:0] init_idx;
  logic             frame_go;
  tx_frame_t        nxt;

  assign init_done = (init_idx == IDX_W'(INIT_LEN));
  assign frame_go  = frame_stb & released & codec_ready_now;
  assign cmd_taken = frame_go & init_done & cmd_pending;

  always_comb begin
    if (!frame_go)       nxt = '0;
    else if (!init_done) nxt = cmd_frame(init_cmd(int'(init_idx)));
    else if (cmd_pending) nxt = cmd_frame(cmd);
    else                 nxt = pcm_frame(pcm_out_l, pcm_out_r);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_idx <= '0;
      tx       <= '0;
    end else if (frame_stb) begin
      tx <= nxt;
      if (frame_go && !init_done) init_idx <= init_idx + 1'b1;
    end
  end
endmodule

// File: rtl/codec_seq_top.sv
module codec_seq_top
  import codec_seq_pkg::*;
#(
  parameter int RST_CYCLES = 64,
  parameter int INIT_LEN   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_stb,
  input  logic [15:0] rx_tag,
  input  logic [19:0] rx_slot1,
  input  logic [19:0] rx_slot2,
  input  logic [19:0] rx_slot3,
  input  logic [19:0] rx_slot4,
  input  logic [19:0] pcm_out_l,
  input  logic [19:0] pcm_out_r,
  input  logic        host_req,
  input  logic        host_rd,
  input  logic [6:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic        host_busy,
  output logic        host_done,
  output logic [6:0]  host_raddr,
  output logic [15:0] host_rdata,
  output logic        codec_rst_n,
  output logic [15:0] tx_tag,
  output logic [19:0] tx_slot1,
  output logic [19:0] tx_slot2,
  output logic [19:0] tx_slot3,
  output logic [19:0] tx_slot4,
  output logic [19:0] pcm_in_l,
  output logic [19:0] pcm_in_r,
  output logic        pcm_in_stb
);
  logic              released;
  logic              codec_ready_now;
  logic              resp_seen;
  logic [REG_AW-1:0] resp_addr;
  logic [REG_DW-1:0] resp_data;
  logic              cmd_pending;
  logic              cmd_taken;
  logic              init_done;
  reg_cmd_t          cmd;
  tx_frame_t         tx;

  codec_rst_timer #(.RST_CYCLES(RST_CYCLES)) rst_tmr_i (
    .clk(clk), .rst_n(rst_n), .released(released)
  );

  codec_status_rx rx_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_tag(rx_tag),
    .rx_slot1(rx_slot1), .rx_slot2(rx_slot2), .rx_slot3(rx_slot3), .rx_slot4(rx_slot4),
    .codec_ready_now(codec_ready_now), .resp_seen(resp_seen),
    .resp_addr(resp_addr), .resp_data(resp_data),
    .pcm_in_l(pcm_in_l), .pcm_in_r(pcm_in_r), .pcm_in_stb(pcm_in_stb)
  );

  codec_host_port host_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .cmd_taken(cmd_taken),
    .resp_seen(resp_seen), .resp_addr(resp_addr), .resp_data(resp_data),
    .cmd_pending(cmd_pending), .cmd(cmd), .host_busy(host_busy),
    .host_done(host_done), .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  codec_frame_builder #(.INIT_LEN(INIT_LEN)) fb_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .released(released),
    .codec_ready_now(codec_ready_now), .cmd_pending(cmd_pending), .cmd(cmd),
    .pcm_out_l(pcm_out_l), .pcm_out_r(pcm_out_r), .cmd_taken(cmd_taken),
    .init_done(init_done), .tx(tx)
  );

  assign codec_rst_n = released;
  assign tx_tag      = tx.tag;
  assign tx_slot1    = tx.s1;
  assign tx_slot2    = tx.s2;
  assign tx_slot3    = tx.s3;
  assign tx_slot4    = tx.s4;
endmodule

// File: rtl/codec_seq_chk.sv
module codec_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_stb,
  input logic [15:0] rx_tag,
  input logic        host_req,
  input logic        host_busy,
  input logic        host_done,
  input logic        codec_rst_n,
  input logic [15:0] tx_tag,
  input logic [19:0] tx_slot1,
  input logic [19:0] tx_slot2,
  input logic [19:0] tx_slot3,
  input logic [19:0] tx_slot4,
  input logic        pcm_in_stb,
  input logic        cmd_taken,
  input logic        cmd_pending,
  input logic        init_done
);
  p_rst_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_n |=> codec_rst_n);

  p_zero_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !rx_tag[15]) |=>
      (tx_tag == 16'h0 && tx_slot1 == 20'h0 && tx_slot2 == 20'h0 &&
       tx_slot3 == 20'h0 && tx_slot4 == 20'h0));

  p_init_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && codec_rst_n && rx_tag[15] && !init_done) |=> tx_tag == 16'hE000);

  p_legal_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (tx_tag == 16'h0 || tx_tag == 16'hE000 ||
                   tx_tag == 16'hC000 || tx_tag == 16'h9800));

  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy) |=> host_busy);

  p_cmd_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |=> !cmd_pending);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !host_busy);

  p_pcm_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> pcm_in_stb);
endmodule

bind codec_seq_top codec_seq_chk chk_i (.*);

// File: tb/codec_seq_top_tb_top.sv
`timescale 1ns/1ps
module codec_seq_top_tb_top;
  localparam int RSTC = 16;
  localparam int NINIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic [15:0] rx_tag = '0;
  logic [19:0] rx_slot1 = '0, rx_slot2 = '0, rx_slot3 = '0, rx_slot4 = '0;
  logic [19:0] pcm_out_l = '0, pcm_out_r = '0;
  logic host_req = 1'b0, host_rd = 1'b0;
  logic [6:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic host_busy, host_done, codec_rst_n, pcm_in_stb;
  logic [6:0] host_raddr;
  logic [15:0] host_rdata;
  logic [15:0] tx_tag;
  logic [19:0] tx_slot1, tx_slot2, tx_slot3, tx_slot4, pcm_in_l, pcm_in_r;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  codec_seq_top #(.RST_CYCLES(RSTC), .INIT_LEN(NINIT)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] t, input logic [19:0] a, input logic [19:0] b,
                       input logic [19:0] c, input logic [19:0] d);
    @(negedge clk);
    rx_tag = t; rx_slot1 = a; rx_slot2 = b; rx_slot3 = c; rx_slot4 = d;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic host_cmd(input logic rd, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_rd = rd; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic chk_frame(input string req, input logic [15:0] t, input logic [19:0] a,
                           input logic [19:0] b, input logic [19:0] c, input logic [19:0] d);
    chk({req, " tag"}, 32'(tx_tag), 32'(t));
    chk({req, " slot1"}, 32'(tx_slot1), 32'(a));
    chk({req, " slot2"}, 32'(tx_slot2), 32'(b));
    chk({req, " slot3"}, 32'(tx_slot3), 32'(c));
    chk({req, " slot4"}, 32'(tx_slot4), 32'(d));
  endtask

  function automatic logic [19:0] exp_init_s1(int i);
    return 20'((2 * i + 2) << 12);
  endfunction

  function automatic logic [19:0] exp_init_s2(int i);
    return 20'((((i ^ 8'hA5) & 8'hFF) << 12) | ((i & 8'hFF) << 4));
  endfunction

  task automatic t_reset_release;
    repeat (3) @(negedge clk);
    chk("R1 reset codec_rst_n", 32'(codec_rst_n), 0);
    chk("R1 reset busy", 32'(host_busy), 0);
    chk("R1 reset done", 32'(host_done), 0);
    chk("R1 reset tag", 32'(tx_tag), 0);
    rst_n = 1'b1;
    frame(16'h8000, 0, 0, 0, 0);
    chk_frame("R2 frame during codec reset", 0, 0, 0, 0, 0);
    repeat (RSTC - 3) @(negedge clk);
    chk("R1 still low", 32'(codec_rst_n), 0);
    @(negedge clk);
    chk("R1 released", 32'(codec_rst_n), 1);
  endtask

  task automatic t_init_and_pending;
    frame(16'h0000, 0, 0, 0, 0);
    chk_frame("R2 not ready", 0, 0, 0, 0, 0);
    host_cmd(1'b0, 7'h18, 16'h1234);
    chk("R5 busy after accept", 32'(host_busy), 1);
    host_cmd(1'b0, 7'h7F, 16'hFFFF);
    chk("R5 busy held", 32'(host_busy), 1);
    for (int i = 0; i < NINIT; i++) begin
      frame(16'h8000, 0, 0, 0, 0);
      chk_frame($sformatf("R3 init entry %0d", i), 16'hE000, exp_init_s1(i), exp_init_s2(i), 0, 0);
      if (i == 0) begin
        frame(16'h0000, 0, 0, 0, 0);
        chk_frame("R2 gap in init", 0, 0, 0, 0, 0);
      end
    end
    pcm_out_l = 20'h11111; pcm_out_r = 20'h22222;
    frame(16'h8000, 0, 0, 0, 0);
    chk_frame("R6 write frame", 16'hE000, {1'b0, 7'h18, 12'h0}, {16'h1234, 4'h0}, 0, 0);
    chk("R9 busy low after write", 32'(host_busy), 0);
    chk("R9 no done on write", 32'(host_done), 0);
    pcm_out_l = 20'h12345; pcm_out_r = 20'h6789A;
    frame(16'h8000, 0, 0, 0, 0);
    chk_frame("R4 R5 pcm frame, ignored request absent", 16'h9800, 0, 0, 20'h12345, 20'h6789A);
  endtask

  task automatic t_read;
    host_cmd(1'b1, 7'h26, 16'hFFFF);
    frame(16'h8000, 0, 0, 0, 0);
    chk_frame("R7 read frame", 16'hC000, {1'b1, 7'h26, 12'h0}, 0, 0, 0);
    chk("R5 busy while read outstanding", 32'(host_busy), 1);
    frame(16'h8000, 0, 0, 0, 0);
    chk("R4 pcm after read", 32'(tx_tag), 32'h9800);
    chk("R8 no early done", 32'(host_done), 0);
    frame(16'hE000, {1'b0, 7'h26, 12'hABC}, {16'hBEEF, 4'h7}, 0, 0);
    chk("R8 done not yet", 32'(host_done), 0);
    @(negedge clk);
    chk("R8 done", 32'(host_done), 1);
    chk("R8 raddr", 32'(host_raddr), 32'h26);
    chk("R8 rdata", 32'(host_rdata), 32'hBEEF);
    chk("R8 busy low", 32'(host_busy), 0);
    @(negedge clk);
    chk("R8 done one cycle", 32'(host_done), 0);
    chk("R8 rdata held", 32'(host_rdata), 32'hBEEF);
  endtask

  task automatic t_stale_status;
    frame(16'hE000, {1'b0, 7'h11, 12'h0}, {16'h4444, 4'h0}, 0, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R8 no done without read", 32'(host_done), 0);
    end
    chk("R8 raddr unchanged", 32'(host_raddr), 32'h26);
  endtask

  task automatic t_pcm_in;
    frame(16'h9800, 0, 0, 20'hABCDE, 20'h13579);
    chk("R10 pcm_in_l", 32'(pcm_in_l), 32'hABCD0);
    chk("R10 pcm_in_r", 32'(pcm_in_r), 32'h13570);
    chk("R10 stb", 32'(pcm_in_stb), 1);
    @(negedge clk);
    chk("R10 stb cleared", 32'(pcm_in_stb), 0);
  endtask

  task automatic t_write_through_not_ready;
    host_cmd(1'b0, 7'h0A, 16'h5555);
    frame(16'h0000, 0, 0, 0, 0);
    chk_frame("R2 zero with pending", 0, 0, 0, 0, 0);
    chk("R2 still pending", 32'(host_busy), 1);
    frame(16'h8000, 0, 0, 0, 0);
    chk_frame("R6 R9 held write sent", 16'hE000, {1'b0, 7'h0A, 12'h0}, {16'h5555, 4'h0}, 0, 0);
    repeat (2) begin
      @(negedge clk);
      chk("R9 no done", 32'(host_done), 0);
    end
    frame(16'h8000, 0, 0, 0, 0);
    chk("R6 back to pcm", 32'(tx_tag), 32'h9800);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset_release();
    t_init_and_pending();
    t_read();
    t_stale_status();
    t_pcm_in();
    t_write_through_not_ready();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule